// File: doc/BRIEF.md
# Double-Data-Rate Prefetch Gearbox

This block sits between a memory-controller core that moves one 2n-bit word per clock and a data bus that moves one n-bit half per clock phase. On the transmit (write) side it accepts a burst command, asks the core for one word per cycle, and drives each word onto the pins as two halves: the lower half while the clock is high and the upper half while it is low. Each half carries its own per-lane mask bits. It also produces the strobe for the burst: a low preamble cycle, a toggle centered in each data half (taken from a supplied quadrature clock), and a half-cycle low postamble.

On the receive (read) side it accepts a read command with a burst length and a latency of 2 or 2.5 cycles. It samples the incoming strobe and data at the middle of every half cycle using both edges of the quadrature clock. Each change of strobe level inside the expected burst window captures one half. Every second captured half completes a 2n-bit word, which is reported with a one-cycle valid pulse. If the window closes on an odd number of captured edges, a one-cycle error pulse is raised and the dangling half is dropped.

Top module: `ddr_gearbox`

## Requirements
- R1: While and after reset, dq_oe, dqs_oe, wr_take, rd_valid and rd_err are low.
- R2: A burst code (wr_bl or rd_bl) of 0 means 1 word, 1 means 2 words, and 2 or 3 means 4 words. For a write, wr_take is high for exactly that many cycles, starting in the cycle after wr_cmd is sampled.
- R3: In the cycle after an accepted wr_cmd, dqs_oe is high, dqs_o is low and dq_oe is low for the whole cycle (preamble).
- R4: A word presented on wr_word during a wr_take cycle is driven in the next cycle with dq_oe high. wr_word[HALF_W-1:0] is driven while clk is high, and wr_word[2*HALF_W-1:HALF_W] while clk is low.
- R5: dm_o carries wr_mask[LANES-1:0] with the lower half and wr_mask[2*LANES-1:LANES] with the upper half. Bit g of each group belongs to data lane g.
- R6: In every data cycle dqs_o follows clk90. It is low for the first quarter, high from a quarter to three quarters, and low for the last quarter, so its edges sit at the middle of each half. dq_oe is never high without dqs_oe.
- R7: In the cycle after the last data cycle, dq_oe is low and dqs_oe is high with dqs_o low during the first half of the cycle only (postamble). dqs_oe is low from the second half on.
- R8: wr_cmd sampled while a write burst is in its preamble or data cycles is ignored: no second preamble follows.
- R9: With rd_cl_half = 0, the first transfer of a read occupies the first half of the second cycle after rd_cmd. With rd_cl_half = 1, it occupies the second half of that cycle. The first captured half becomes rd_word[HALF_W-1:0] and the second becomes the upper half. Word k is presented with a one-cycle rd_valid in cycle 3 + k + rd_cl_half after the command.
- R10: A read half counts as a transfer only when the strobe level sampled at its middle differs from the level sampled at the previous half-middle, and only inside the burst window. Strobe changes outside the window produce no rd_valid.
- R11: If the read window closes with an odd number of captured edges, rd_err is high for one cycle, in cycle rd_words + 2 + rd_cl_half after the command. No word is produced from the unmatched half.
- R12: rd_cmd sampled while a read window is open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; commands are sampled on its rising edge |
| clk90 | input | 1 | Same clock delayed a quarter period |
| rst | input | 1 | Synchronous active-high reset |
| wr_cmd | input | 1 | Start a write burst |
| wr_bl | input | 2 | Write burst code |
| wr_take | output | 1 | Core must present wr_word/wr_mask this cycle |
| wr_word | input | 2*HALF_W | Write word, lower half sent first |
| wr_mask | input | 2*LANES | Lane masks, lower group with lower half |
| dq_o | output | HALF_W | Data pins, transmit value |
| dq_oe | output | 1 | Data pin drive enable |
| dm_o | output | LANES | Mask pins, per lane |
| dqs_o | output | 1 | Strobe, transmit value |
| dqs_oe | output | 1 | Strobe drive enable |
| rd_cmd | input | 1 | Start a read burst window |
| rd_bl | input | 2 | Read burst code |
| rd_cl_half | input | 1 | 0: latency 2, 1: latency 2.5 |
| dq_i | input | HALF_W | Data pins, received value |
| dqs_i | input | 1 | Strobe, received value |
| rd_valid | output | 1 | One pulse per reassembled word |
| rd_word | output | 2*HALF_W | Reassembled read word |
| rd_err | output | 1 | Window closed on an odd edge count |

## Verification
On every cycle the assertions check how the write enables nest: a data cycle always has the strobe enabled, data drive is always preceded by a strobe-only preamble, and data drive stops with the strobe already released. They also check that the last wr_take cycle is followed by a data cycle and that rd_err never lasts two cycles. The bench scenarios are needed for everything that depends on half-cycle position and content: the order of halves and masks on the pins, the quarter-cycle strobe placement, the arrival cycle of read words under both latencies, and rejection of out-of-window strobe edges and of commands issued mid-burst.

// File: rtl/ddr_gb_pkg.sv
package ddr_gb_pkg;

  localparam int MAX_WORDS = 4;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_PRE  = 2'd1,
    TX_DATA = 2'd2
  } tx_state_e;

  // burst code to number of core words: 0->1, 1->2, 2/3->4
  function automatic logic [2:0] words_of(input logic [1:0] code);
    case (code)
      2'd0:    words_of = 3'd1;
      2'd1:    words_of = 3'd2;
      default: words_of = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/ddr_gb_tx.sv
module ddr_gb_tx
  import ddr_gb_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  clk90,
  input  logic                  rst,
  input  logic                  cmd,
  input  logic [1:0]            bl,
  output logic                  take,
  input  logic [2*HALF_W-1:0]   word,
  input  logic [2*(HALF_W/LANE_W)-1:0] mask,
  output logic [HALF_W-1:0]     dq_o,
  output logic                  dq_oe,
  output logic [HALF_W/LANE_W-1:0] dm_o,
  output logic                  dqs_o,
  output logic                  dqs_oe
);

  localparam int LANES = HALF_W / LANE_W;

  tx_state_e                state_q;
  logic [2:0]               rem_q;
  logic [HALF_W-1:0]        lo_q, hi_q;
  logic [LANES-1:0]         mlo_q, mhi_q;
  logic                     post_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TX_IDLE;
      rem_q   <= '0;
      take    <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      mlo_q   <= '0;
      mhi_q   <= '0;
    end else begin
      case (state_q)
        TX_IDLE: begin
          if (cmd) begin
            state_q <= TX_PRE;
            rem_q   <= words_of(bl);
            take    <= 1'b1;
          end
        end
        TX_PRE, TX_DATA: begin
          if (state_q == TX_PRE || rem_q != 3'd0) begin
            state_q <= TX_DATA;
            lo_q    <= word[HALF_W-1:0];
            hi_q    <= word[2*HALF_W-1:HALF_W];
            mlo_q   <= mask[LANES-1:0];
            mhi_q   <= mask[2*LANES-1:LANES];
            rem_q   <= rem_q - 3'd1;
            take    <= (rem_q > 3'd1);
          end else begin
            state_q <= TX_IDLE;
            take    <= 1'b0;
          end
        end
        default: begin
          state_q <= TX_IDLE;
          take    <= 1'b0;
        end
      endcase
    end
  end

  // half-cycle extension of the strobe enable after the last data cycle
  always_ff @(negedge clk) begin
    if (rst) post_q <= 1'b0;
    else     post_q <= (state_q == TX_DATA);
  end

  assign dq_oe  = (state_q == TX_DATA);
  assign dqs_oe = (state_q != TX_IDLE) | post_q;
  assign dqs_o  = dq_oe & clk90;

  // per-lane phase select: lower half while clk is high
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dq_o[g*LANE_W +: LANE_W] = clk ? lo_q[g*LANE_W +: LANE_W]
                                          : hi_q[g*LANE_W +: LANE_W];
    assign dm_o[g] = clk ? mlo_q[g] : mhi_q[g];
  end

endmodule

// File: rtl/ddr_gb_rx_cap.sv
module ddr_gb_rx_cap #(
  parameter int HALF_W = 16
) (
  input  logic              clk90,
  input  logic              rst,
  input  logic [HALF_W-1:0] dq_i,
  input  logic              dqs_i,
  output logic [HALF_W-1:0] a_dq,
  output logic              a_s,
  output logic [HALF_W-1:0] b_dq,
  output logic              b_s
);

  // middle of the first clock half
  always_ff @(posedge clk90) begin
    if (rst) begin
      a_dq <= '0;
      a_s  <= 1'b0;
    end else begin
      a_dq <= dq_i;
      a_s  <= dqs_i;
    end
  end

  // middle of the second clock half
  always_ff @(negedge clk90) begin
    if (rst) begin
      b_dq <= '0;
      b_s  <= 1'b0;
    end else begin
      b_dq <= dq_i;
      b_s  <= dqs_i;
    end
  end

endmodule

// File: rtl/ddr_gb_rx.sv
module ddr_gb_rx
  import ddr_gb_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd,
  input  logic [1:0]          bl,
  input  logic                cl_half,
  input  logic [HALF_W-1:0]   a_dq,
  input  logic                a_s,
  input  logic [HALF_W-1:0]   b_dq,
  input  logic                b_s,
  output logic                rd_valid,
  output logic [2*HALF_W-1:0] rd_word,
  output logic                rd_err
);

  localparam int IDX_W = $clog2(6 + 2 * MAX_WORDS) + 1;
  localparam int CYC_W = IDX_W - 1;

  logic              armed_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [IDX_W-1:0]  first_q, last_q;
  logic              prev_q;
  logic              hl_q;
  logic [HALF_W-1:0] lo_q;

  logic [IDX_W-1:0]    idx_a, idx_b, first_n;
  logic                ev_a, ev_b, close_n;
  logic                hl_a, hl_n, v_n;
  logic [HALF_W-1:0]   lo_a, lo_n;
  logic [2*HALF_W-1:0] w_n;

  assign first_n = IDX_W'(4) + IDX_W'(cl_half);

  always_comb begin
    idx_a = {cyc_q, 1'b0};
    idx_b = {cyc_q, 1'b1};
    ev_a  = armed_q && (idx_a >= first_q) && (idx_a <= last_q) && (a_s != prev_q);
    ev_b  = armed_q && (idx_b >= first_q) && (idx_b <= last_q) && (b_s != a_s);

    v_n  = 1'b0;
    w_n  = '0;
    hl_a = hl_q;
    lo_a = lo_q;
    if (ev_a) begin
      if (hl_q) begin
        v_n  = 1'b1;
        w_n  = {a_dq, lo_q};
        hl_a = 1'b0;
      end else begin
        lo_a = a_dq;
        hl_a = 1'b1;
      end
    end

    hl_n = hl_a;
    lo_n = lo_a;
    if (ev_b) begin
      if (hl_a) begin
        v_n  = 1'b1;
        w_n  = {b_dq, lo_a};
        hl_n = 1'b0;
      end else begin
        lo_n = b_dq;
        hl_n = 1'b1;
      end
    end

    close_n = armed_q && (idx_b >= last_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      cyc_q    <= '0;
      first_q  <= '0;
      last_q   <= '0;
      prev_q   <= 1'b0;
      hl_q     <= 1'b0;
      lo_q     <= '0;
      rd_valid <= 1'b0;
      rd_word  <= '0;
      rd_err   <= 1'b0;
    end else begin
      prev_q   <= b_s;
      rd_valid <= v_n;
      rd_err   <= close_n && hl_n;
      if (v_n) rd_word <= w_n;
      if (armed_q) begin
        cyc_q <= cyc_q + CYC_W'(1);
        lo_q  <= lo_n;
        hl_q  <= close_n ? 1'b0 : hl_n;
        if (close_n) armed_q <= 1'b0;
      end else if (cmd) begin
        armed_q <= 1'b1;
        cyc_q   <= '0;
        hl_q    <= 1'b0;
        first_q <= first_n;
        last_q  <= first_n + IDX_W'({words_of(bl), 1'b0}) - IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/ddr_gearbox.sv
module ddr_gearbox #(
  parameter int HALF_W = 16,
  parameter int LANE_W = 8
) (
  input  logic                          clk,
  input  logic                          clk90,
  input  logic                          rst,
  input  logic                          wr_cmd,
  input  logic [1:0]                    wr_bl,
  output logic                          wr_take,
  input  logic [2*HALF_W-1:0]           wr_word,
  input  logic [2*(HALF_W/LANE_W)-1:0]  wr_mask,
  output logic [HALF_W-1:0]             dq_o,
  output logic                          dq_oe,
  output logic [HALF_W/LANE_W-1:0]      dm_o,
  output logic                          dqs_o,
  output logic                          dqs_oe,
  input  logic                          rd_cmd,
  input  logic [1:0]                    rd_bl,
  input  logic                          rd_cl_half,
  input  logic [HALF_W-1:0]             dq_i,
  input  logic                          dqs_i,
  output logic                          rd_valid,
  output logic [2*HALF_W-1:0]           rd_word,
  output logic                          rd_err
);

  logic [HALF_W-1:0] a_dq, b_dq;
  logic              a_s, b_s;

  ddr_gb_tx #(.HALF_W(HALF_W), .LANE_W(LANE_W)) u_tx (
    .clk    (clk),
    .clk90  (clk90),
    .rst    (rst),
    .cmd    (wr_cmd),
    .bl     (wr_bl),
    .take   (wr_take),
    .word   (wr_word),
    .mask   (wr_mask),
    .dq_o   (dq_o),
    .dq_oe  (dq_oe),
    .dm_o   (dm_o),
    .dqs_o  (dqs_o),
    .dqs_oe (dqs_oe)
  );

  ddr_gb_rx_cap #(.HALF_W(HALF_W)) u_cap (
    .clk90 (clk90),
    .rst   (rst),
    .dq_i  (dq_i),
    .dqs_i (dqs_i),
    .a_dq  (a_dq),
    .a_s   (a_s),
    .b_dq  (b_dq),
    .b_s   (b_s)
  );

  ddr_gb_rx #(.HALF_W(HALF_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .cmd      (rd_cmd),
    .bl       (rd_bl),
    .cl_half  (rd_cl_half),
    .a_dq     (a_dq),
    .a_s      (a_s),
    .b_dq     (b_dq),
    .b_s      (b_s),
    .rd_valid (rd_valid),
    .rd_word  (rd_word),
    .rd_err   (rd_err)
  );

endmodule

// File: rtl/ddr_gearbox_chk.sv
module ddr_gearbox_chk (
  input logic clk,
  input logic rst,
  input logic wr_take,
  input logic dq_oe,
  input logic dqs_oe,
  input logic rd_err
);

  // R6: data drive never without the strobe driven
  assert_oe_nest_R6: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> dqs_oe);

  // R3: data drive starts only after a strobe-only preamble cycle
  assert_preamble_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> $past(dqs_oe));

  // R7: when data drive ends, the strobe is already released
  assert_postamble_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(dq_oe) |-> !dqs_oe);

  // R2: the last word request is followed by a data cycle
  assert_take_tail_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(wr_take) |-> dq_oe);

  // R11: the error indication is a single-cycle pulse
  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rd_err |=> !rd_err);

endmodule

bind ddr_gearbox ddr_gearbox_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_take (wr_take),
  .dq_oe   (dq_oe),
  .dqs_oe  (dqs_oe),
  .rd_err  (rd_err)
);

// File: tb/ddr_gearbox_tb.sv
module ddr_gearbox_tb;

  localparam int HALF_W = 16;
  localparam int LANE_W = 8;
  localparam int LANES  = HALF_W / LANE_W;

  logic clk = 1'b0, clk90 = 1'b0, rst = 1'b1;
  logic wr_cmd = 1'b0, rd_cmd = 1'b0, rd_cl_half = 1'b0, dqs_i = 1'b0;
  logic [1:0] wr_bl = '0, rd_bl = '0;
  logic [2*HALF_W-1:0] wr_word = '0;
  logic [2*LANES-1:0]  wr_mask = '0;
  logic [HALF_W-1:0]   dq_i = '0;
  logic wr_take, dq_oe, dqs_o, dqs_oe, rd_valid, rd_err;
  logic [HALF_W-1:0]   dq_o;
  logic [LANES-1:0]    dm_o;
  logic [2*HALF_W-1:0] rd_word;

  int checks = 0, errors = 0, seed = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  initial begin #5; forever #10 clk90 = ~clk90; end

  ddr_gearbox #(.HALF_W(HALF_W), .LANE_W(LANE_W)) u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nwords(input int c);
    return (c == 0) ? 1 : (c == 1) ? 2 : 4;
  endfunction

  function automatic logic [2*HALF_W-1:0] mkword(input int k);
    return 32'(((seed * 7 + k) * 32'h0137_2B4D) ^ 32'hA5C3_1E0F);
  endfunction

  function automatic logic [2*LANES-1:0] mkmask(input int k);
    return 4'((seed + k * 5) % 16);
  endfunction

  task automatic do_write(input int blc, input bit poke);
    int w = nwords(blc);
    seed++;
    @(negedge clk); wr_cmd = 1'b1; wr_bl = 2'(blc);
    @(posedge clk); #3; wr_cmd = 1'b0;
    chk("R3 preamble dqs_oe", 64'(dqs_oe), 64'd1);
    chk("R3 preamble dqs_o", 64'(dqs_o), 64'd0);
    chk("R3 preamble dq_oe", 64'(dq_oe), 64'd0);
    chk("R2 take first", 64'(wr_take), 64'd1);
    wr_word = mkword(0); wr_mask = mkmask(0);
    #10;
    chk("R3 preamble late dqs_o", 64'(dqs_o), 64'd0);
    chk("R3 preamble late dqs_oe", 64'(dqs_oe), 64'd1);
    for (int c = 1; c <= w; c++) begin
      logic [2*HALF_W-1:0] ew;
      logic [2*LANES-1:0]  em;
      ew = mkword(c - 1); em = mkmask(c - 1);
      @(posedge clk); #3;
      if (poke && c == 1) wr_cmd = 1'b1;
      if (c == 2) wr_cmd = 1'b0;
      chk("R4 dq_oe", 64'(dq_oe), 64'd1);
      chk("R4 lower half", 64'(dq_o), 64'(ew[HALF_W-1:0]));
      chk("R5 lower mask", 64'(dm_o), 64'(em[LANES-1:0]));
      chk("R6 dqs first quarter", 64'(dqs_o), 64'd0);
      chk("R2 take", 64'(wr_take), 64'(c < w));
      if (c < w) begin wr_word = mkword(c); wr_mask = mkmask(c); end
      #5;  chk("R6 dqs second quarter", 64'(dqs_o), 64'd1);
      #5;  chk("R4 upper half", 64'(dq_o), 64'(ew[2*HALF_W-1:HALF_W]));
           chk("R5 upper mask", 64'(dm_o), 64'(em[2*LANES-1:LANES]));
           chk("R6 dqs third quarter", 64'(dqs_o), 64'd1);
      #5;  chk("R6 dqs last quarter", 64'(dqs_o), 64'd0);
           chk("R6 dqs_oe in data", 64'(dqs_oe), 64'd1);
    end
    @(posedge clk); #3; wr_cmd = 1'b0;
    chk("R7 dq_oe off", 64'(dq_oe), 64'd0);
    chk("R7 postamble dqs_oe", 64'(dqs_oe), 64'd1);
    chk("R7 postamble dqs_o", 64'(dqs_o), 64'd0);
    chk("R2 take off", 64'(wr_take), 64'd0);
    #10;
    chk("R7 strobe released", 64'(dqs_oe), 64'd0);
    @(posedge clk); #3;
    chk("R8 no restart dqs_oe", 64'(dqs_oe), 64'd0);
    chk("R8 no restart take", 64'(wr_take), 64'd0);
  endtask

  // mode 0: clean burst, 1: odd edge count, 2: stray strobe edges and mid-window command
  task automatic do_read(input int blc, input int clh, input int mode);
    int w = nwords(blc);
    int f = 4 + clh;
    int l = f + 2 * w - 1;
    int ncyc = w + 6;
    string tag = (mode == 0) ? "R9" : (mode == 1) ? "R11" : "R10 R12";
    seed++;
    @(negedge clk); rd_cmd = 1'b1; rd_bl = 2'(blc); rd_cl_half = 1'(clh);
    for (int h = 0; h < 2 * ncyc; h++) begin
      int i = h - f;
      if (h % 2 == 0) @(posedge clk); else @(negedge clk);
      if (h == 1) rd_cmd = 1'b0;
      if (mode == 2 && h == 3) rd_cmd = 1'b1;
      if (mode == 2 && h == 5) rd_cmd = 1'b0;
      if (i >= 0 && i < 2 * w) begin
        logic [2*HALF_W-1:0] ww;
        ww = mkword(i / 2);
        dq_i  = (i % 2 == 0) ? ww[HALF_W-1:0] : ww[2*HALF_W-1:HALF_W];
        dqs_i = (mode == 1) ? 1'b1 : (i % 2 == 0);
      end else if (mode == 2 && (h == 1 || h == l + 1)) begin
        dq_i  = 16'hDEAD;
        dqs_i = 1'b1;
      end else begin
        dq_i  = 16'h5A5A;
        dqs_i = 1'b0;
      end
      if (h % 2 == 0) begin
        int c = h / 2;
        int k = c - 3 - clh;
        bit ev = (mode != 1) && k >= 0 && k < w;
        bit ee = (mode == 1) && c == w + 2 + clh;
        #3;
        chk({tag, " rd_valid"}, 64'(rd_valid), 64'(ev));
        if (ev) chk({tag, " rd_word"}, 64'(rd_word), 64'(mkword(k)));
        chk({tag, " rd_err"}, 64'(rd_err), 64'(ee));
      end
    end
    dqs_i = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #3;
    chk("R1 in reset dq_oe", 64'(dq_oe), 64'd0);
    chk("R1 in reset dqs_oe", 64'(dqs_oe), 64'd0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(posedge clk);
    #3;
    chk("R1 idle dq_oe", 64'(dq_oe), 64'd0);
    chk("R1 idle dqs_oe", 64'(dqs_oe), 64'd0);
    chk("R1 idle take", 64'(wr_take), 64'd0);
    chk("R1 idle rd_valid", 64'(rd_valid), 64'd0);
    chk("R1 idle rd_err", 64'(rd_err), 64'd0);
    for (int b = 0; b < 4; b++)
      for (int p = 0; p < 2; p++) begin
        do_write(b, p[0]);
        repeat (2) @(posedge clk);
      end
    for (int b = 0; b < 4; b++)
      for (int c = 0; c < 2; c++)
        for (int m = 0; m < 3; m++) begin
          do_read(b, c, m);
          repeat (3) @(posedge clk);
        end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule